// File: doc/BRIEF.md
# Byte-FIFO Serial Port Register Block

This block is the host-facing register file of a serial port. A bus master reads and writes 32-bit words at byte offsets inside a 0x28-byte window. Through this window it queues outgoing bytes, collects incoming bytes and programs the port. It can also read a live picture of both queues. The block does not shift bits onto a wire. A separate agent empties the outgoing queue and fills the incoming queue through a side interface. That agent also reports line errors as one-cycle pulses. The stored bit-rate divisor and control byte are driven out for that agent to use.

The block has a single level interrupt. It is gated by an enable bit in the modem-control byte. The interrupt is raised by any line error, by the outgoing queue running dry, or by a receive-ready flag. The receive-ready flag is set a programmable number of cycles after a byte is accepted into the incoming queue. Writing the key value 0x55 to the reset offset restores every register and empties both queues, with no reset pin.

Offsets used by the bus: 0x00 data, 0x04 control (write) / status (read), 0x08 modem control, 0x0C divisor, 0x10 queue status, 0x14 outgoing count, 0x18 incoming count, 0x20 reset key, 0x24 loop-back port. Any other offset reads as 0.

Top module: `uart_regfile`

## Requirements
- R1: After reset the status word (0x04) reads 0x40, queue status (0x10) reads 0x11, modem control, divisor and both counts read 0, and irq is low.
- R2: A write to 0x00 appends bus_wdata[7:0] to the outgoing queue. ext_tx_valid and ext_tx_data present the oldest byte, and 0x14 reads the number of queued bytes.
- R3: A write to 0x00 while the outgoing queue holds TX_DEPTH bytes is dropped. The count stays at TX_DEPTH, and queue-status bit2 (outgoing full) reads 1.
- R4: A read of 0x00 removes the oldest incoming byte and returns it on bus_rdata one cycle later. A read with the queue empty returns 0.
- R5: While modem-control bit5 (receive enable) is 0, bytes offered to the incoming queue are discarded.
- R6: A byte offered while the incoming queue holds RX_DEPTH bytes is discarded, and queue-status bit6 (incoming full) reads 1.
- R7: A pop that empties the outgoing queue sets status bit5 (sent) and bit6 (outgoing empty) and queue-status bit0. The next write to 0x00 clears status bit5 and bit6.
- R8: err_parity, err_frame, err_overrun and err_break pulses set status bits 0, 1, 2 and 3, which stay set. A 0x00 read that empties the incoming queue clears bit2.
- R9: Status bit7 (receive ready) becomes 1 exactly RX_DELAY cycles after the edge that accepts an incoming byte. It stays 1 until the status word is read. That read still returns it as 1.
- R10: irq is 1 exactly when modem-control bit2 is 1 and at least one of status bits 0, 1, 2, 3, 5 or 7 is 1.
- R11: Writing exactly 0x55 to 0x20 empties both queues and returns every register to its reset value. Any other value is stored and reads back from 0x20.
- R12: A nonzero write to 0x0C is stored and driven on baud_div, and a write of 0 leaves it unchanged. A write to 0x04 is driven on ctrl_out.
- R13: A write to 0x24 offers bus_wdata[7:0] to the incoming queue, under the same rules as the side port, which wins if both offer in one cycle. A read of 0x24 removes the oldest outgoing byte and returns it, or returns 0 when empty.
- R14: Queue status bit1 / bit3 read 1 when the outgoing count is at least TX_DEPTH/2 / 3*TX_DEPTH/4. Bit5 / bit7 do the same for the incoming count against RX_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte offset in the register window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ext_tx_pop | input | 1 | Side agent removes the oldest outgoing byte |
| ext_tx_valid | output | 1 | Outgoing queue is not empty |
| ext_tx_data | output | 8 | Oldest outgoing byte |
| ext_rx_push | input | 1 | Side agent offers an incoming byte |
| ext_rx_data | input | 8 | Incoming byte |
| err_parity | input | 1 | Parity error pulse |
| err_frame | input | 1 | Framing error pulse |
| err_overrun | input | 1 | Overrun pulse |
| err_break | input | 1 | Break or fragment pulse |
| ctrl_out | output | 8 | Stored control byte |
| baud_div | output | DIV_W | Stored bit-rate divisor |
| irq | output | 1 | Interrupt request, level |

## Verification
Register writes, queue pushes, pops and error pulses take effect at the edge that samples them. irq, queue status, counts and ext_tx_data are combinational from that state, so the bench samples them at the falling edge after the edge that sampled the stimulus. bus_rdata is registered, so a monitor compares each read one falling edge after its strobe against the value that the read task queued. For the receive-ready delay, the bench counts falling edges from the accepting edge. It checks that irq is still low after RX_DELAY-1 edges and high after RX_DELAY edges.

// File: rtl/uart_rf_pkg.sv
// Package: offsets and bit positions shared by the serial-port register block
// and its checker. Assumes a byte-addressed window of 0x28 with word registers.
package uart_rf_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_MODEM = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DIV   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_QSTAT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_TXCNT = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_RXCNT = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_KEY   = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_LOOP  = 6'h24;

    localparam logic [31:0] RESET_KEY = 32'h0000_0055;

    // modem-control bit positions
    localparam int MB_IRQ_EN = 2;
    localparam int MB_RX_EN  = 5;

    // status word bit positions
    localparam int SB_SENT   = 5;
    localparam int SB_TXEMPT = 6;
    localparam int SB_RXRDY  = 7;
    localparam int SB_OVR    = 2;

    // level flags of one queue
    typedef struct packed {
        logic high;
        logic full;
        logic low;
        logic empty;
    } qflags_t;
endpackage

// File: rtl/byte_fifo.sv
// Module: byte_fifo
// Circular byte queue with show-ahead output and occupancy count.
// Assumes DEPTH is a power of two; push when full and pop when empty are
// ignored here, callers gate them. clr empties the queue synchronously.
module byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL_V = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_push = push && (count != FULL_V);
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rd_ptr];

    // storage write, no reset needed on the array
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/fifo_flags.sv
// Module: fifo_flags
// Decodes a queue occupancy into empty, half, three-quarter and full flags.
// Assumes DEPTH is at least 4 so the thresholds are distinct from full/empty.
module fifo_flags
    import uart_rf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] count,
    output qflags_t       flags
);
    localparam logic [CW-1:0] LOW_V  = CW'(DEPTH / 2);
    localparam logic [CW-1:0] HIGH_V = CW'((3 * DEPTH) / 4);
    localparam logic [CW-1:0] FULL_V = CW'(DEPTH);

    // level compare
    always_comb begin
        flags.empty = (count == '0);
        flags.low   = (count >= LOW_V);
        flags.high  = (count >= HIGH_V);
        flags.full  = (count == FULL_V);
    end
endmodule

// File: rtl/rx_irq_delay.sv
// Module: rx_irq_delay
// One-shot delay: fire pulses DELAY edges after the edge that sampled arm.
// Arm while already counting is ignored so the first arrival sets the time.
// Assumes DELAY >= 1; DELAY == 1 uses a plain register.
module rx_irq_delay #(
    parameter int DELAY = 500000,
    localparam int CW   = $clog2(DELAY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    output logic fire
);
    generate
        if (DELAY <= 1) begin : g_short
            // single-cycle delay
            always_ff @(posedge clk) begin
                if (!rst_n || clr) fire <= 1'b0;
                else               fire <= arm;
            end
        end else begin : g_count
            logic [CW-1:0] remain;
            logic          busy;
            assign fire = busy && (remain == CW'(1));
            // countdown from DELAY to the firing cycle
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    busy   <= 1'b0;
                    remain <= '0;
                end else if (busy) begin
                    if (remain == CW'(1)) busy <= 1'b0;
                    remain <= remain - 1'b1;
                end else if (arm) begin
                    busy   <= 1'b1;
                    remain <= CW'(DELAY);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/uart_regfile.sv
// Module: uart_regfile
// Word register window in front of an outgoing and an incoming byte queue.
// Decodes strobed single-cycle accesses, keeps control, modem, divisor and
// status state, raises a gated level interrupt. Assumes bus_wr and bus_rd
// are one-cycle strobes and that a key write of 0x55 acts as a full reset.
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int TX_DEPTH = 32,
    parameter int RX_DEPTH = 16,
    parameter int RX_DELAY = 500000,
    parameter int DIV_W    = 16,
    localparam int TCW     = $clog2(TX_DEPTH) + 1,
    localparam int RCW     = $clog2(RX_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ext_tx_pop,
    output logic              ext_tx_valid,
    output logic [7:0]        ext_tx_data,
    input  logic              ext_rx_push,
    input  logic [7:0]        ext_rx_data,
    input  logic              err_parity,
    input  logic              err_frame,
    input  logic              err_overrun,
    input  logic              err_break,
    output logic [7:0]        ctrl_out,
    output logic [DIV_W-1:0]  baud_div,
    output logic              irq
);
    logic [7:0]      ctrl_q, modem_q, key_q;
    logic [DIV_W-1:0] div_q;
    logic [3:0]      err_q;
    logic            sent_q, rxrdy_q;
    logic [TCW-1:0]  tx_count;
    logic [RCW-1:0]  rx_count;
    logic [7:0]      tx_head, rx_head, rx_in_data;
    qflags_t         txf, rxf;
    logic [7:0]      status, qstat;
    logic            soft_rst, tx_push, tx_pop, rx_push, rx_pop, rx_offer;
    logic            tx_drained, rx_drained, rx_fire, stat_read;

    // access decode
    always_comb begin
        soft_rst   = bus_wr && bus_addr == OFS_KEY && bus_wdata == RESET_KEY;
        tx_push    = bus_wr && bus_addr == OFS_DATA && !txf.full;
        tx_pop     = (ext_tx_pop || (bus_rd && bus_addr == OFS_LOOP)) && !txf.empty;
        rx_offer   = ext_rx_push || (bus_wr && bus_addr == OFS_LOOP);
        rx_in_data = ext_rx_push ? ext_rx_data : bus_wdata[7:0];
        rx_push    = rx_offer && modem_q[MB_RX_EN] && !rxf.full;
        rx_pop     = bus_rd && bus_addr == OFS_DATA && !rxf.empty;
        tx_drained = tx_pop && tx_count == TCW'(1) && !tx_push;
        rx_drained = rx_pop && rx_count == RCW'(1) && !rx_push;
        stat_read  = bus_rd && bus_addr == OFS_CTRL;
    end

    byte_fifo #(.DEPTH(TX_DEPTH), .DW(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(tx_push), .din(bus_wdata[7:0]), .pop(tx_pop),
        .dout(tx_head), .count(tx_count)
    );

    byte_fifo #(.DEPTH(RX_DEPTH), .DW(8)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .push(rx_push), .din(rx_in_data), .pop(rx_pop),
        .dout(rx_head), .count(rx_count)
    );

    fifo_flags #(.DEPTH(TX_DEPTH)) u_txf (.count(tx_count), .flags(txf));
    fifo_flags #(.DEPTH(RX_DEPTH)) u_rxf (.count(rx_count), .flags(rxf));

    rx_irq_delay #(.DELAY(RX_DELAY)) u_rxdly (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .arm(rx_push), .fire(rx_fire)
    );

    // assembled read words
    always_comb begin
        status = {rxrdy_q, txf.empty, sent_q, 1'b0, err_q};
        qstat  = {rxf.high, rxf.full, rxf.low, rxf.empty,
                  txf.high, txf.full, txf.low, txf.empty};
    end

    // software-visible register state
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q  <= '0;
            modem_q <= '0;
            key_q   <= '0;
            div_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL:  ctrl_q  <= bus_wdata[7:0];
                OFS_MODEM: modem_q <= bus_wdata[7:0];
                OFS_KEY:   key_q   <= bus_wdata[7:0];
                OFS_DIV:   if (bus_wdata != '0) div_q <= bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // sticky error, sent and receive-ready flags
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            err_q   <= '0;
            sent_q  <= 1'b0;
            rxrdy_q <= 1'b0;
        end else begin
            err_q <= err_q | {err_break, err_overrun, err_frame, err_parity};
            if (rx_drained && !err_overrun) err_q[SB_OVR] <= 1'b0;
            if (tx_push)         sent_q <= 1'b0;
            else if (tx_drained) sent_q <= 1'b1;
            if (rx_fire)        rxrdy_q <= 1'b1;
            else if (stat_read) rxrdy_q <= 1'b0;
        end
    end

    // registered read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (bus_addr)
                OFS_DATA:  bus_rdata <= rxf.empty ? 32'd0 : {24'd0, rx_head};
                OFS_CTRL:  bus_rdata <= {24'd0, status};
                OFS_MODEM: bus_rdata <= {24'd0, modem_q};
                OFS_DIV:   bus_rdata <= 32'(div_q);
                OFS_QSTAT: bus_rdata <= {24'd0, qstat};
                OFS_TXCNT: bus_rdata <= 32'(tx_count);
                OFS_RXCNT: bus_rdata <= 32'(rx_count);
                OFS_KEY:   bus_rdata <= {24'd0, key_q};
                OFS_LOOP:  bus_rdata <= txf.empty ? 32'd0 : {24'd0, tx_head};
                default:   bus_rdata <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        irq          = modem_q[MB_IRQ_EN] &&
                       (|{status[SB_RXRDY], status[SB_SENT], status[3:0]});
        ext_tx_valid = !txf.empty;
        ext_tx_data  = tx_head;
        ctrl_out     = ctrl_q;
        baud_div     = div_q;
    end
endmodule

// File: rtl/uart_regfile_chk.sv
// Module: uart_regfile_chk
// Property checker bound into uart_regfile. Observes ports and internal
// state only; drives nothing. Assumes the bind below supplies the signals.
module uart_regfile_chk
    import uart_rf_pkg::*;
#(
    parameter int TX_DEPTH = 32,
    parameter int RX_DEPTH = 16,
    parameter int DIV_W    = 16,
    localparam int TCW     = $clog2(TX_DEPTH) + 1,
    localparam int RCW     = $clog2(RX_DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [5:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [31:0]      bus_wdata,
    input logic             ext_tx_pop,
    input logic             ext_rx_push,
    input logic             err_overrun,
    input logic             irq,
    input logic [7:0]       modem,
    input logic [7:0]       status,
    input logic [TCW-1:0]   tx_count,
    input logic [RCW-1:0]   rx_count,
    input logic [DIV_W-1:0] baud
);
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !modem[MB_IRQ_EN] |-> !irq);  // R10
    AST_IRQ_ON_SENT: assert property (@(posedge clk) disable iff (!rst_n)
        (modem[MB_IRQ_EN] && status[SB_SENT]) |-> irq);  // R10
    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DATA && tx_count == TCW'(TX_DEPTH) && !ext_tx_pop)
        |=> tx_count == TCW'(TX_DEPTH));  // R3
    AST_RX_DROP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rx_push && !modem[MB_RX_EN] && !bus_wr && !bus_rd) |=> $stable(rx_count));  // R5
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_KEY && bus_wdata == RESET_KEY)
        |=> (tx_count == '0 && rx_count == '0 && status == 8'h40 && baud == '0));  // R11
    AST_DIV_ZERO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIV && bus_wdata == '0) |=> $stable(baud));  // R12
    AST_OVR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_DATA && rx_count == RCW'(1) && !ext_rx_push && !err_overrun)
        |=> !status[SB_OVR]);  // R8
    AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= RCW'(RX_DEPTH));  // R6
endmodule

bind uart_regfile uart_regfile_chk #(
    .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .DIV_W(DIV_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .ext_tx_pop(ext_tx_pop),
    .ext_rx_push(ext_rx_push), .err_overrun(err_overrun), .irq(irq),
    .modem(modem_q), .status(status), .tx_count(tx_count),
    .rx_count(rx_count), .baud(div_q)
);

// File: tb/uart_regfile_tb_top.sv
// Bench: scoreboard for reads (driver queues expectations, monitor compares
// bus_rdata one falling edge after each read strobe) plus direct checks of
// combinational outputs at falling edges.
module uart_regfile_tb_top;
    localparam int TXD = 8, RXD = 4, DLY = 12, DIV_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic ext_tx_pop = 1'b0, ext_tx_valid, ext_rx_push = 1'b0;
    logic [7:0] ext_tx_data, ext_rx_data = '0, ctrl_out;
    logic err_parity = 1'b0, err_frame = 1'b0, err_overrun = 1'b0, err_break = 1'b0;
    logic [DIV_W-1:0] baud_div;
    logic irq;

    int n_checks = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    uart_regfile #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .RX_DELAY(DLY), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_tx_pop(ext_tx_pop), .ext_tx_valid(ext_tx_valid),
        .ext_tx_data(ext_tx_data), .ext_rx_push(ext_rx_push),
        .ext_rx_data(ext_rx_data), .err_parity(err_parity),
        .err_frame(err_frame), .err_overrun(err_overrun),
        .err_break(err_break), .ctrl_out(ctrl_out), .baud_div(baud_div),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic side_push(input logic [7:0] d);
        ext_rx_data = d; ext_rx_push = 1'b1;
        @(negedge clk);
        ext_rx_push = 1'b0;
    endtask

    task automatic side_pop();
        ext_tx_pop = 1'b1;
        @(negedge clk);
        ext_tx_pop = 1'b0;
    endtask

    // monitor: compare each read result one falling edge after its strobe
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1 irq", 32'(irq), 0);
        rd(6'h04, 32'h40, "R1 status");
        rd(6'h10, 32'h11, "R1 qstat");
        rd(6'h08, 0, "R1 modem");
        rd(6'h0C, 0, "R1 div");
        rd(6'h14, 0, "R1 txcnt");
        rd(6'h18, 0, "R1 rxcnt");
        // R2 outgoing queue
        wr(6'h00, 32'hA1); wr(6'h00, 32'hB2); wr(6'h00, 32'hC3);
        chk("R2 valid", 32'(ext_tx_valid), 1);
        chk("R2 head", 32'(ext_tx_data), 32'hA1);
        rd(6'h14, 3, "R2 txcnt");
        rd(6'h04, 32'h00, "R2 status");
        rd(6'h10, 32'h10, "R14 qstat below thresholds");
        side_pop();
        chk("R2 head order", 32'(ext_tx_data), 32'hB2);
        rd(6'h24, 32'hB2, "R13 loop read");
        side_pop();
        // R7 drain
        rd(6'h04, 32'h60, "R7 status drained");
        rd(6'h10, 32'h11, "R7 qstat drained");
        rd(6'h24, 0, "R13 loop read empty");
        wr(6'h00, 32'h5A);
        rd(6'h04, 32'h00, "R7 sent cleared");
        for (int i = 1; i < 8; i++) wr(6'h00, 32'h10 + i);
        wr(6'h00, 32'hEE); wr(6'h00, 32'hEE);
        // R3 overflow dropped
        rd(6'h14, TXD, "R3 txcnt");
        rd(6'h10, 32'h1E, "R3 R14 qstat full");
        for (int i = 0; i < 8; i++) begin
            chk("R3 order", 32'(ext_tx_data), (i == 0) ? 32'h5A : 32'h10 + i);
            side_pop();
        end
        rd(6'h04, 32'h60, "R7 status again");
        chk("R10 irq off while disabled", 32'(irq), 0);
        // R10 gate
        wr(6'h08, 32'h04);
        chk("R10 irq on", 32'(irq), 1);
        wr(6'h08, 32'h00);
        chk("R10 irq off", 32'(irq), 0);
        // R5 receive disabled
        side_push(8'h33);
        rd(6'h18, 0, "R5 dropped");
        // R12 divisor and control
        wr(6'h0C, 100);
        wr(6'h0C, 0);
        chk("R12 div kept", 32'(baud_div), 100);
        wr(6'h04, 32'h3C);
        chk("R12 ctrl", 32'(ctrl_out), 32'h3C);
        // R11 keyed reset
        wr(6'h00, 32'h77);
        wr(6'h20, 32'hAA);
        rd(6'h20, 32'hAA, "R11 key stored");
        wr(6'h20, 32'h55);
        rd(6'h20, 0, "R11 key cleared");
        rd(6'h14, 0, "R11 txcnt");
        chk("R11 valid", 32'(ext_tx_valid), 0);
        chk("R11 div", 32'(baud_div), 0);
        chk("R11 ctrl", 32'(ctrl_out), 0);
        rd(6'h04, 32'h40, "R11 status");
        // R9 receive-ready delay
        wr(6'h08, 32'h24);
        chk("R9 irq idle", 32'(irq), 0);
        ext_rx_data = 8'h41; ext_rx_push = 1'b1;
        @(negedge clk);
        ext_rx_push = 1'b0;
        repeat (DLY - 1) @(negedge clk);
        chk("R9 not yet", 32'(irq), 0);
        @(negedge clk);
        chk("R9 fired", 32'(irq), 1);
        rd(6'h04, 32'hC0, "R9 status ready");
        chk("R9 cleared by read", 32'(irq), 0);
        rd(6'h18, 1, "R4 rxcnt");
        rd(6'h00, 32'h41, "R4 pop");
        rd(6'h00, 0, "R4 empty read");
        // R8 errors and overrun clear
        err_overrun = 1'b1; err_parity = 1'b1;
        @(negedge clk);
        err_overrun = 1'b0; err_parity = 1'b0;
        chk("R10 irq on error", 32'(irq), 1);
        rd(6'h04, 32'h45, "R8 errors");
        wr(6'h24, 32'h52);
        rd(6'h18, 1, "R13 loop write");
        rd(6'h00, 32'h52, "R13 loop byte");
        rd(6'h04, 32'h41, "R8 overrun cleared");
        repeat (15) @(negedge clk);
        rd(6'h04, 32'hC1, "R9 second arrival");
        err_frame = 1'b1; err_break = 1'b1;
        @(negedge clk);
        err_frame = 1'b0; err_break = 1'b0;
        rd(6'h04, 32'h4B, "R8 frame break sticky");
        // R6 / R14 incoming levels
        side_push(8'h60); side_push(8'h61);
        rd(6'h10, 32'h21, "R14 rx half");
        side_push(8'h62); side_push(8'h63); side_push(8'h64);
        rd(6'h18, RXD, "R6 rxcnt");
        rd(6'h10, 32'hE1, "R6 R14 qstat full");
        for (int i = 0; i < 4; i++) rd(6'h00, 32'h60 + i, "R6 order");
        rd(6'h10, 32'h11, "R6 qstat empty");
        finish_run();
    end
endmodule